// File: doc/BRIEF.md
# Burst Column Sequencer for SDRAM Accesses

This block turns the starting column of an SDRAM read or write into the column address of each beat, one beat per clock. A start strobe captures the start column, a three-bit length code, the wrap-order bit and the access direction. On each following cycle the block presents one column together with a valid flag. A final-beat flag marks the end of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned window of that size. Within the window the beats follow either a rising order or an XOR order. A full-page burst walks every column of the row, wrapping at the top, until a stop input ends it. A single-write option cuts write bursts to one beat and leaves reads at the programmed length. A memory controller's data path and a device-side model can both drive the same generator. Bank, row, latency and burst-termination handling belong elsewhere.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and after it is released with no start, `beat_valid` and `beat_last` are low.
- R2: A start sampled at a rising edge makes `beat_valid` high after that edge, with `beat_col` equal to the sampled `start_col` (beat 0).
- R3: Length code 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. The unused codes 3'b100, 3'b101 and 3'b110 give a 1-beat burst.
- R4: With `wrap_xor` = 0 and a fixed length BL, beat i carries the low log2(BL) bits equal to (start low bits + i) mod BL. The upper column bits stay those of `start_col`.
- R5: With `wrap_xor` = 1 and a fixed length BL, beat i carries the low log2(BL) bits equal to the start low bits XOR i. The upper bits stay fixed.
- R6: `beat_last` is high on the final beat of a fixed burst and on no other beat. `beat_valid` is low on the cycle after that beat unless a new start arrives.
- R7: Code 3'b111 selects full page. The column rises by one per beat and wraps from 255 to 0. `wrap_xor` has no effect, and `beat_last` stays low.
- R8: In a full-page burst, `stop` high at a rising edge during a valid beat makes `beat_valid` low after that edge. In a fixed burst `stop` has no effect.
- R9: With `is_write` = 1 and `single_write` = 1 every burst is one beat, whatever the code, including full page. With `is_write` = 0 the programmed length is kept.
- R10: A start during a running burst abandons it. The beat after that edge is beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst with the values below |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code |
| wrap_xor | input | 1 | 1 = XOR order, 0 = rising order |
| is_write | input | 1 | Access is a write |
| single_write | input | 1 | Shorten writes to one beat |
| stop | input | 1 | End a full-page burst |
| beat_col | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_last | output | 1 | Final beat of a fixed burst |

## Verification
Every result is due exactly one rising edge after its cause. Beat 0 follows the edge that sampled the start, and beat i follows i edges later. The drop of `beat_valid` follows the edge that sampled the final beat or the stop. The bench drives inputs at falling edges and samples outputs at the next falling edge, so each check lands half a cycle after the edge that produced the result. The table-driven loop compares every beat with a model that works the column out through modular arithmetic. The directed tests check full-page wrap, stop, restart and the ignored inputs at those same points.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   localparam int CODE_W = 3;
   localparam logic [CODE_W-1:0] CODE_FULL_PAGE = 3'b111;
   localparam int MAX_FIXED_LOG2 = 3;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
   import colgen_pkg::*;
#(
   parameter int COL_W = 8,
   parameter bit HAS_XOR = 1'b1
) (
   input  logic [CODE_W-1:0] len_code,
   input  logic              wrap_xor,
   input  logic              is_write,
   input  logic              single_write,
   output logic [COL_W-1:0]  win_mask,
   output logic              full_page,
   output logic              xor_eff
);
   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic one_beat;
   logic code_fixed;
   logic xor_req;

   assign one_beat   = is_write & single_write;
   assign code_fixed = (len_code[CODE_W-1] == 1'b0);

   generate
      if (HAS_XOR) begin : g_xor
         assign xor_req = wrap_xor;
      end else begin : g_noxor
         assign xor_req = 1'b0;
      end
   endgenerate

   always_comb begin
      full_page = 1'b0;
      win_mask  = '0;
      if (!one_beat) begin
         if (len_code == CODE_FULL_PAGE) begin
            full_page = 1'b1;
            win_mask  = '1;
         end else if (code_fixed) begin
            win_mask = (ONE << len_code[1:0]) - ONE;
         end
      end
   end

   assign xor_eff = xor_req & ~full_page;
endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat_idx,
   input  logic [COL_W-1:0] win_mask,
   input  logic             use_xor,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] rising;
   logic [COL_W-1:0] mixed;
   logic [COL_W-1:0] low_part;

   assign rising   = base_col + beat_idx;
   assign mixed    = base_col ^ beat_idx;
   assign low_part = use_xor ? mixed : rising;
   assign col      = (base_col & ~win_mask) | (low_part & win_mask);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
   import colgen_pkg::*;
#(
   parameter int COL_W = 8,
   parameter bit HAS_XOR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_code,
   input  logic             wrap_xor,
   input  logic             is_write,
   input  logic             single_write,
   input  logic             stop,
   output logic [COL_W-1:0] beat_col,
   output logic             beat_valid,
   output logic             beat_last
);
   localparam int WIN_MAX = 1 << MAX_FIXED_LOG2;

   generate
      if (COL_W < MAX_FIXED_LOG2) begin : g_bad_width
         $fatal(1, "COL_W must cover the largest fixed burst window");
      end
      if ((1 << COL_W) < WIN_MAX) begin : g_bad_window
         $fatal(1, "page smaller than fixed burst window");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   logic             dec_full;
   logic             dec_xor;

   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] mask_q;
   logic [COL_W-1:0] idx_q;
   logic             full_q;
   logic             xor_q;
   logic             valid_q;
   logic             final_beat;

   colgen_len_decode #(.COL_W(COL_W), .HAS_XOR(HAS_XOR)) i_dec (
      .len_code     (len_code),
      .wrap_xor     (wrap_xor),
      .is_write     (is_write),
      .single_write (single_write),
      .win_mask     (dec_mask),
      .full_page    (dec_full),
      .xor_eff      (dec_xor)
   );

   colgen_order #(.COL_W(COL_W)) i_order (
      .base_col (base_q),
      .beat_idx (idx_q),
      .win_mask (mask_q),
      .use_xor  (xor_q),
      .col      (beat_col)
   );

   assign final_beat = valid_q & ~full_q & (idx_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '0;
         idx_q   <= '0;
         full_q  <= 1'b0;
         xor_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (start) begin
         base_q  <= start_col;
         mask_q  <= dec_mask;
         idx_q   <= '0;
         full_q  <= dec_full;
         xor_q   <= dec_xor;
         valid_q <= 1'b1;
      end else if (valid_q) begin
         if ((full_q && stop) || final_beat) begin
            valid_q <= 1'b0;
         end else begin
            idx_q <= idx_q + COL_W'(1);
         end
      end
   end

   assign beat_valid = valid_q;
   assign beat_last  = final_beat;

   AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (beat_valid && beat_col == $past(start_col))); // R2

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_last && !start) |=> !beat_valid); // R6

   AST_FIXED_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last && !full_q && !start) |=> beat_valid); // R8

   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_last && !full_q && !start)
      |=> (((beat_col ^ $past(beat_col)) & ~mask_q) == '0)); // R4

   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && full_q && !stop && !start)
      |=> (beat_valid && beat_col == COL_W'($past(beat_col) + COL_W'(1)))); // R7

   AST_PAGE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && full_q && stop && !start) |=> !beat_valid); // R8
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] start_col = '0;
   logic [2:0] len_code = '0;
   logic       wrap_xor = 1'b0;
   logic       is_write = 1'b0;
   logic       single_write = 1'b0;
   logic       stop = 1'b0;
   logic [7:0] beat_col;
   logic       beat_valid;
   logic       beat_last;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sdram_burst_colgen i_sdram_burst_colgen (
      .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
      .len_code(len_code), .wrap_xor(wrap_xor), .is_write(is_write),
      .single_write(single_write), .stop(stop), .beat_col(beat_col),
      .beat_valid(beat_valid), .beat_last(beat_last)
   );

   // vector: {start_col[8], code[3], xor[1], write[1], single[1], beats[4]}
   localparam int NV = 12;
   localparam logic [17:0] VEC [NV] = '{
      {8'h40, 3'b000, 1'b0, 1'b0, 1'b0, 4'd1},
      {8'h41, 3'b001, 1'b0, 1'b0, 1'b0, 4'd2},
      {8'h13, 3'b010, 1'b0, 1'b0, 1'b0, 4'd4},
      {8'h2D, 3'b011, 1'b0, 1'b0, 1'b0, 4'd8},
      {8'h2D, 3'b011, 1'b1, 1'b0, 1'b0, 4'd8},
      {8'h96, 3'b010, 1'b1, 1'b0, 1'b0, 4'd4},
      {8'hFF, 3'b001, 1'b1, 1'b0, 1'b0, 4'd2},
      {8'h55, 3'b100, 1'b0, 1'b0, 1'b0, 4'd1},
      {8'h56, 3'b110, 1'b1, 1'b0, 1'b0, 4'd1},
      {8'h7E, 3'b011, 1'b0, 1'b1, 1'b1, 4'd1},
      {8'h7E, 3'b011, 1'b0, 1'b0, 1'b1, 4'd8},
      {8'h7E, 3'b011, 1'b1, 1'b1, 1'b0, 4'd8}
   };

   function automatic logic [7:0] ref_col(logic [7:0] base, int bl, bit xo, int i);
      int lo, hi, off;
      lo = base % bl;
      hi = base - lo;
      off = xo ? (lo ^ i) : ((lo + i) % bl);
      return 8'(hi + off);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic launch(logic [7:0] c, logic [2:0] code, bit xo, bit wr, bit sw);
      start = 1'b1; start_col = c; len_code = code;
      wrap_xor = xo; is_write = wr; single_write = sw;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic fixed_burst(logic [7:0] c, logic [2:0] code, bit xo, bit wr,
                              bit sw, int beats, bit hold_stop);
      launch(c, code, xo, wr, sw);
      stop = hold_stop;
      for (int i = 0; i < beats; i++) begin
         chk("R2/R3 valid", 32'(beat_valid), 32'd1);
         chk(xo ? "R5 col" : "R4 col", 32'(beat_col), 32'(ref_col(c, beats, xo, i)));
         chk("R6 last", 32'(beat_last), 32'(i == beats - 1));
         @(negedge clk);
      end
      chk("R6 end valid", 32'(beat_valid), 32'd0);
      chk("R6 end last", 32'(beat_last), 32'd0);
      stop = 1'b0;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk("R1 valid in reset", 32'(beat_valid), 32'd0);
      chk("R1 last in reset", 32'(beat_last), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 valid idle", 32'(beat_valid), 32'd0);
      chk("R1 last idle", 32'(beat_last), 32'd0);

      for (int v = 0; v < NV; v++) begin
         fixed_burst(VEC[v][17:10], VEC[v][9:7], VEC[v][6], VEC[v][5],
                     VEC[v][4], int'(VEC[v][3:0]), 1'b0);
      end

      // R8: stop ignored during a fixed 4-beat burst
      fixed_burst(8'h0A, 3'b010, 1'b0, 1'b0, 1'b0, 4, 1'b1);

      // R7: full page wraps 255 -> 0, xor ignored, no last; R8 stop ends it
      launch(8'hFD, 3'b111, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) begin
         chk("R7 page valid", 32'(beat_valid), 32'd1);
         chk("R7 page col", 32'(beat_col), 32'(8'(8'hFD + i)));
         chk("R7 page last", 32'(beat_last), 32'd0);
         if (i == 5) stop = 1'b1;
         @(negedge clk);
      end
      stop = 1'b0;
      chk("R8 page stopped", 32'(beat_valid), 32'd0);

      // R9: single write cuts a full-page write to one beat
      launch(8'h20, 3'b111, 1'b0, 1'b1, 1'b1);
      chk("R9 one beat valid", 32'(beat_valid), 32'd1);
      chk("R9 one beat col", 32'(beat_col), 32'h20);
      chk("R9 one beat last", 32'(beat_last), 32'd1);
      @(negedge clk);
      chk("R9 ended", 32'(beat_valid), 32'd0);

      // R10: restart during an 8-beat burst
      launch(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
      chk("R10 first beat0", 32'(beat_col), 32'h10);
      @(negedge clk);
      chk("R10 first beat1", 32'(beat_col), 32'h11);
      launch(8'h23, 3'b010, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin
         chk("R10 valid", 32'(beat_valid), 32'd1);
         chk("R10 col", 32'(beat_col), 32'(ref_col(8'h23, 4, 1'b0, i)));
         chk("R10 last", 32'(beat_last), 32'(i == 3));
         @(negedge clk);
      end
      chk("R10 end", 32'(beat_valid), 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule